// File: doc/BRIEF.md
# Single Instruction Repeat Controller

This block lets an instruction sequencer run the next fetched instruction several times in a row. A repeat instruction loads a count into the controller. The count can come from a data memory word or from an immediate operand, and each source has its own load strobe. The value loaded is one less than the number of executions wanted. While a repeat is in progress, the controller holds the program counter so the fetch stage issues the same instruction again. It also raises a flag that tells the execution stage to run normally multicycle operations in pipelined form, at one cycle per iteration.

After a load, each instruction-complete strobe decrements the count while it is nonzero. A completion that arrives with the count at zero ends the repeat, and normal fetch resumes. The current count is always visible on an output so that it can be saved and restored around a context switch.

Top module: `irep_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `rpt_active_o`, `pc_hold_o` and `single_cyc_o` are 0 and `count_o` is 0.
- R2: When the block is idle, a cycle with `ld_mem_i` high makes `rpt_active_o` 1 and `count_o` equal to that cycle's `mem_val_i` from the next cycle on.
- R3: When the block is idle, a cycle with `ld_imm_i` high and `ld_mem_i` low makes `rpt_active_o` 1 and `count_o` equal to that cycle's `imm_val_i` from the next cycle on.
- R4: When both load strobes are high in the same idle cycle, the memory value is taken if `MEM_FIRST` is 1 (the default), and the immediate value otherwise.
- R5: A cycle with `done_i` high, `rpt_active_o` high and `count_o` nonzero lowers `count_o` by one in the next cycle, and the repeat stays active.
- R6: `pc_hold_o` is 1 exactly when `rpt_active_o` is 1 and `count_o` is nonzero. A cycle with `done_i` high, `rpt_active_o` high and `count_o` zero clears `rpt_active_o` in the next cycle. A loaded value N therefore allows exactly N+1 completions.
- R7: `single_cyc_o` equals `rpt_active_o` in every cycle.
- R8: Load strobes that arrive while `rpt_active_o` is 1 are ignored. `count_o` changes only through R5.
- R9: `done_i` has no effect while the block is idle. `count_o` keeps its value (0 after a finished repeat) and `rpt_active_o` stays 0.
- R10: The full counter range works. A loaded value of 2^CNT_W-1 (255 by default) counts down through every value to 0 and gives 2^CNT_W completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_mem_i | input | 1 | Load strobe for the count taken from a data memory word |
| mem_val_i | input | CNT_W | Count value from data memory (executions minus one) |
| ld_imm_i | input | 1 | Load strobe for the count taken from an immediate operand |
| imm_val_i | input | CNT_W | Count value from the immediate operand (executions minus one) |
| done_i | input | 1 | Instruction-complete strobe |
| rpt_active_o | output | 1 | A repeat is in progress |
| pc_hold_o | output | 1 | Fetch stage must hold the program counter and re-issue |
| single_cyc_o | output | 1 | Execution stage runs multicycle operations in pipelined single-cycle form |
| count_o | output | CNT_W | Current counter value, for context save |

## Verification
The bench aims at the boundaries of the count. A loaded zero must give exactly one execution with no PC hold; a design that decrements before checking for zero would wrap to 255 and repeat far too long. A full-scale 255 load runs through every value down to zero, which catches an off-by-one that ends the repeat a cycle early or late. It also drives loads into an active repeat, where a design that reloads would stretch the repeat. It sends completions while idle, which a careless counter would turn into a wrap. It raises both strobes in the same cycle, where the wrong priority would load the immediate value.

// File: rtl/irep_pkg.sv
package irep_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } irep_state_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MEM  = 2'd1,
      SRC_IMM  = 2'd2
   } irep_src_e;

   localparam int unsigned IREP_MAX_W = 16;

endpackage

// File: rtl/irep_src_sel.sv
module irep_src_sel
   import irep_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          MEM_FIRST = 1'b1
) (
   input  logic             ld_mem,
   input  logic [CNT_W-1:0] mem_val,
   input  logic             ld_imm,
   input  logic [CNT_W-1:0] imm_val,
   output logic             load_req,
   output logic [CNT_W-1:0] load_val
);

   irep_src_e src;

   generate
      if (MEM_FIRST) begin : g_mem_first
         always_comb begin
            if (ld_mem)      src = SRC_MEM;
            else if (ld_imm) src = SRC_IMM;
            else             src = SRC_NONE;
         end
      end else begin : g_imm_first
         always_comb begin
            if (ld_imm)      src = SRC_IMM;
            else if (ld_mem) src = SRC_MEM;
            else             src = SRC_NONE;
         end
      end
   endgenerate

   always_comb begin
      load_req = (src != SRC_NONE);
      case (src)
         SRC_MEM: load_val = mem_val;
         SRC_IMM: load_val = imm_val;
         default: load_val = '0;
      endcase
   end

endmodule

// File: rtl/irep_state.sv
module irep_state
   import irep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_req,
   input  logic done,
   input  logic cnt_zero,
   output logic take_load,
   output logic advance,
   output logic active
);

   irep_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (load_req)         st_d = ST_RUN;
         ST_RUN:  if (done && cnt_zero) st_d = ST_IDLE;
         default:                       st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign active    = (st_q == ST_RUN);
   assign take_load = (st_q == ST_IDLE) && load_req;
   assign advance   = (st_q == ST_RUN) && done;

endmodule

// File: rtl/irep_counter.sv
module irep_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             advance,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_zero
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (take_load)             cnt_q <= load_val;
      else if (advance && !cnt_zero)  cnt_q <= cnt_q - ONE;
   end

   assign cnt      = cnt_q;
   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/irep_ctrl.sv
module irep_ctrl
   import irep_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter bit          MEM_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_mem_i,
   input  logic [CNT_W-1:0] mem_val_i,
   input  logic             ld_imm_i,
   input  logic [CNT_W-1:0] imm_val_i,
   input  logic             done_i,
   output logic             rpt_active_o,
   output logic             pc_hold_o,
   output logic             single_cyc_o,
   output logic [CNT_W-1:0] count_o
);

   generate
      if (CNT_W < 1 || CNT_W > IREP_MAX_W) begin : g_bad_width
         $error("irep_ctrl: CNT_W out of range");
      end
   endgenerate

   logic             load_req;
   logic [CNT_W-1:0] load_val;
   logic             take_load;
   logic             advance;
   logic             active;
   logic             cnt_zero;
   logic [CNT_W-1:0] cnt;

   irep_src_sel #(.CNT_W(CNT_W), .MEM_FIRST(MEM_FIRST)) u_sel (
      .ld_mem   (ld_mem_i),
      .mem_val  (mem_val_i),
      .ld_imm   (ld_imm_i),
      .imm_val  (imm_val_i),
      .load_req (load_req),
      .load_val (load_val)
   );

   irep_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (load_req),
      .done      (done_i),
      .cnt_zero  (cnt_zero),
      .take_load (take_load),
      .advance   (advance),
      .active    (active)
   );

   irep_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_load (take_load),
      .load_val  (load_val),
      .advance   (advance),
      .cnt       (cnt),
      .cnt_zero  (cnt_zero)
   );

   assign rpt_active_o = active;
   assign pc_hold_o    = active && !cnt_zero;
   assign single_cyc_o = active;
   assign count_o      = cnt;

endmodule

// File: rtl/irep_ctrl_chk.sv
module irep_ctrl_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_mem_i,
   input logic             ld_imm_i,
   input logic             done_i,
   input logic             rpt_active_o,
   input logic             pc_hold_o,
   input logic             single_cyc_o,
   input logic [CNT_W-1:0] count_o
);

   AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rpt_active_o && (ld_mem_i || ld_imm_i)) |=> rpt_active_o); // R2

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_active_o && done_i && count_o != '0) |=>
         (rpt_active_o && count_o == $past(count_o) - CNT_W'(1))); // R5

   AST_REPEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_active_o && done_i && count_o == '0) |=> !rpt_active_o); // R6

   AST_HOLD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold_o |-> (rpt_active_o && count_o != '0)); // R6

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      single_cyc_o == rpt_active_o); // R7

   AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_active_o && !done_i) |=> (rpt_active_o && $stable(count_o))); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rpt_active_o && !ld_mem_i && !ld_imm_i) |=>
         (!rpt_active_o && $stable(count_o))); // R9

endmodule

bind irep_ctrl irep_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_mem_i     (ld_mem_i),
   .ld_imm_i     (ld_imm_i),
   .done_i       (done_i),
   .rpt_active_o (rpt_active_o),
   .pc_hold_o    (pc_hold_o),
   .single_cyc_o (single_cyc_o),
   .count_o      (count_o)
);

// File: tb/sim_irep_ctrl.sv
`timescale 1ns/1ps
module sim_irep_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_mem_i = 1'b0, ld_imm_i = 1'b0, done_i = 1'b0;
   logic [7:0] mem_val_i = '0, imm_val_i = '0;
   logic       rpt_active_o, pc_hold_o, single_cyc_o;
   logic [7:0] count_o;

   always #2.5 clk = ~clk;

   irep_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .ld_mem_i(ld_mem_i), .mem_val_i(mem_val_i),
      .ld_imm_i(ld_imm_i), .imm_val_i(imm_val_i),
      .done_i(done_i),
      .rpt_active_o(rpt_active_o), .pc_hold_o(pc_hold_o),
      .single_cyc_o(single_cyc_o), .count_o(count_o)
   );

   int         n_chk = 0, n_err = 0, n_done_seen = 0;
   bit         m_act = 1'b0;
   logic [7:0] m_cnt = '0;
   bit         finished = 1'b0;

   function automatic bit exp_hold(bit a, logic [7:0] c);
      return a && (c != 8'd0);
   endfunction

   task automatic chk1(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk1(tag, "count", int'(count_o), int'(m_cnt));
      chk1(tag, "active", int'(rpt_active_o), int'(m_act));
      chk1("R6", "pc_hold", int'(pc_hold_o), int'(exp_hold(m_act, m_cnt)));
      chk1("R7", "single_cyc", int'(single_cyc_o), int'(m_act));
   endtask

   task automatic cyc(bit lm, logic [7:0] mv, bit li, logic [7:0] iv, bit dn, string tag);
      @(negedge clk);
      ld_mem_i = lm; mem_val_i = mv; ld_imm_i = li; imm_val_i = iv; done_i = dn;
      @(posedge clk);
      if (!m_act) begin
         if (lm)      begin m_cnt = mv; m_act = 1'b1; end
         else if (li) begin m_cnt = iv; m_act = 1'b1; end
      end else if (dn) begin
         n_done_seen++;
         if (m_cnt == 8'd0) m_act = 1'b0;
         else               m_cnt = m_cnt - 8'd1;
      end
      #1;
      chk_all(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 chk_all("R1");
      @(negedge clk) rst_n = 1'b1;
      #1 chk_all("R1");

      // R9: done while idle after reset
      cyc(0, 8'd0, 0, 8'd0, 1, "R9");
      cyc(0, 8'd0, 0, 8'd0, 1, "R9");

      // R2 + R5 + R6: memory load 3, four completions, done gaps between
      cyc(1, 8'd3, 0, 8'd0, 0, "R2");
      cyc(0, 8'd0, 0, 8'd0, 0, "R8");
      n_done_seen = 0;
      while (m_act) cyc(0, 8'd0, 0, 8'd0, 1, "R5");
      chk1("R6", "completions for 3", n_done_seen, 4);

      // R3: immediate load of 0 gives exactly one completion, no hold
      cyc(0, 8'd0, 1, 8'd0, 0, "R3");
      chk1("R3", "hold after zero load", int'(pc_hold_o), 0);
      n_done_seen = 0;
      cyc(0, 8'd0, 0, 8'd0, 1, "R6");
      chk1("R6", "completions for 0", n_done_seen, 1);

      // R4: both strobes together, memory wins
      cyc(1, 8'd5, 1, 8'd9, 0, "R4");
      chk1("R4", "priority value", int'(count_o), 5);

      // R8: loads while active are ignored
      cyc(1, 8'd200, 0, 8'd0, 0, "R8");
      cyc(0, 8'd0, 1, 8'd100, 1, "R8");
      cyc(1, 8'd77, 1, 8'd66, 0, "R8");
      chk1("R8", "count kept", int'(count_o), 4);
      while (m_act) cyc(1, 8'd9, 0, 8'd0, 1, "R8");

      // R9: idle done after finish keeps zero
      cyc(0, 8'd0, 0, 8'd0, 1, "R9");
      chk1("R9", "idle count", int'(count_o), 0);

      // R10: full scale
      cyc(0, 8'd0, 1, 8'd255, 0, "R10");
      n_done_seen = 0;
      while (m_act) cyc(0, 8'd0, 0, 8'd0, 1, "R10");
      chk1("R10", "completions for 255", n_done_seen, 256);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit         lm = ($urandom % 6) == 0;
         bit         li = ($urandom % 6) == 0;
         bit         dn = ($urandom % 3) != 0;
         logic [7:0] mv = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
         logic [7:0] iv = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
         string      tg;
         if (!m_act && lm)      tg = li ? "R4" : "R2";
         else if (!m_act && li) tg = "R3";
         else if (!m_act)       tg = "R9";
         else if (lm || li)     tg = "R8";
         else                   tg = "R5";
         cyc(lm, mv, li, iv, dn, tg);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule